// File: doc/BRIEF.md
# Dual-style nibble register port

This block is the host-side register port of a tone signalling unit. A microcontroller talks to it over a 4-bit data bus. A strap input selects one of two bus styles. In the strobe-pair style, separate read and write strobes are used, and a 2-bit address is captured from the low data lines when the address-latch pin falls. In the clocked style, one strobe acts as a bus clock, a read/write pin gives the direction, and the address-latch pin serves as a single address bit.

Behind the port there are two registers that can only be written: a transmit code register and a control register. Two sources can only be read: the receive code, taken from the detector side, and a status nibble. The status nibble carries the receiver-busy indication (active low), two tone-detector flags and an event flag. The event flag latches any new detection. It is cleared when the host finishes reading the status, or by itself once every detector has gone quiet. Every bus pin passes through a synchronizer into the system clock domain, and strobe edges are found there. The tri-state pad is left outside the block, which supplies a data-out value and an output enable.

Top module: `nibble_bus_regs`

## Requirements
- R1: After reset the transmit code and all control outputs are 0, the bus is not driven, and the status nibble reads 4'b1000.
- R2: In strobe-pair style (pair_style=1), d_in[1:0] is captured as the address when ale falls. The rising edge of wr_n with cs_n=0 writes d_in to the transmit register when the address is 2'b00, and to the control register when it is 2'b10. Writes to addresses 2'b01 and 2'b11, and writes with cs_n=1, change nothing.
- R3: In strobe-pair style, while rd_n=0 and cs_n=0, the port drives the receive code for address 2'b01 and the status nibble for address 2'b11. For addresses 2'b00 and 2'b10, d_oe stays 0.
- R4: In clocked style (pair_style=0), the falling edge of rd_n with cs_n=0 and wr_n=0 writes d_in to the control register when ale=1 and to the transmit register when ale=0. With cs_n=1 nothing is written.
- R5: In clocked style, the rising edge of rd_n with cs_n=0 and wr_n=1 captures ale as the read select (1 selects status, 0 selects the receive code). Data is driven while rd_n stays high and released once it is low.
- R6: Control bit 3 drives tone_b_en, bit 2 fast_mode, bit 1 det_en and bit 0 tx_en.
- R7: Status bit 3 is the receiver-busy indication (0 while a valid code is present), bit 2 the fax-tone flag, bit 1 the call-progress flag and bit 0 the event flag.
- R8: The event flag sets when bit 3 goes from 1 to 0, when the fax flag goes from 0 to 1, or when the call-progress flag goes from 0 to 1.
- R9: The event flag clears when a status read ends: on the rising edge of rd_n in strobe-pair style, or on the falling edge of rd_n in clocked style. A new event in the same cycle takes priority.
- R10: The event flag clears without a read once bit 3 is 1 and both tone flags are 0.
- R11: While det_en=0, the fax and call-progress flags and the fax_det and cpt_det outputs stay 0, so they cannot raise the event flag.
- R12: The fax flag and fax_det are 0 whenever the call-progress tone is present.
- R13: While pwr_down=1, the transmit and control registers are held at 0, writes are ignored, and the status nibble reads 4'b1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_style | input | 1 | Strap: 1 for separate strobes, 0 for clocked bus |
| pwr_down | input | 1 | Power-down, synchronous to clk |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe (pair style) or bus clock (clocked style) |
| wr_n | input | 1 | Write strobe (pair style) or read/write select (clocked style) |
| ale | input | 1 | Address-latch strobe (pair style) or register select bit (clocked style) |
| d_in | input | DATA_W | Data bus, input side of the pad |
| d_out | output | DATA_W | Data bus, output side of the pad (0 when not driven) |
| d_oe | output | 1 | Pad output enable |
| rx_code | input | DATA_W | Received code from the detector |
| rx_idle | input | 1 | Receiver busy indication, 0 while a valid code is present |
| fax_tone | input | 1 | Raw fax-tone detection |
| cpt_tone | input | 1 | Raw call-progress detection |
| tx_code | output | DATA_W | Transmit code register |
| tone_b_en | output | 1 | Control bit 3 |
| fast_mode | output | 1 | Control bit 2 |
| det_en | output | 1 | Control bit 1 |
| tx_en | output | 1 | Control bit 0 |
| fax_det | output | 1 | Gated fax-tone flag |
| cpt_det | output | 1 | Gated call-progress flag |

## Verification
The bench goes after the edges that share pins across the two styles. If the design used the wrong strobe edge, it would write on the leading edge of rd_n in clocked style, or take the address from the wrong ale transition, and the transmit register would pick up stale data. It also exercises the event flag at its priorities: clearing at the end of a status read, clearing by itself when every detector is idle, and setting from the fax flag only after call progress has gone. A design that mixed these up would report a stale event or miss a new one. Detector gating and power-down are checked by reading the status while raw detections are still present, so a missing gate shows up as a nonzero flag on the bus.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

   localparam int NIB_W = 4;
   localparam int ADR_W = 2;

   // synchronized view of the bus pins, one field per pin group
   typedef struct packed {
      logic             cs_n;
      logic             strb;   // read strobe or bus clock
      logic             rw;     // write strobe or read/write select
      logic             ale;
      logic [NIB_W-1:0] dat;
   } bus_t;

   typedef struct packed {
      logic tone_b_en;
      logic fast_mode;
      logic det_en;
      logic tx_en;
   } ctrl_t;

   typedef struct packed {
      logic spb;   // 0 while a valid code is present
      logic fax;
      logic cpt;
      logic evt;
   } status_t;

   localparam logic [ADR_W-1:0] ADR_TX   = 2'b00;
   localparam logic [ADR_W-1:0] ADR_CTRL = 2'b10;
   localparam logic [ADR_W-1:0] ADR_STAT = 2'b11;

   localparam bus_t    BUS_IDLE  = '{cs_n: 1'b1, strb: 1'b1, rw: 1'b1, ale: 1'b0, dat: '0};
   localparam status_t STAT_IDLE = '{spb: 1'b1, fax: 1'b0, cpt: 1'b0, evt: 1'b0};

endpackage

// File: rtl/nbr_sync.sv
module nbr_sync #(
   parameter int             W       = 8,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nbr_sync needs at least two stages");
      end
      if (W < 1) begin : g_bad_width
         $error("nbr_sync width must be positive");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/nbr_decode.sv
module nbr_decode
   import nbr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pair_style,
   input  bus_t             s,
   output logic             wr_tx,
   output logic             wr_ctrl,
   output logic [NIB_W-1:0] wdata,
   output logic             rd_clr,
   output logic             drive,
   output logic             sel_stat
);

   logic             p_ale, p_strb, p_rw;
   logic [ADR_W-1:0] adr_q;
   logic             rph_q, rsel_q;
   logic             ale_fall, strb_fall, strb_rise, rw_rise;

   assign ale_fall  =  p_ale  & ~s.ale;
   assign strb_fall =  p_strb & ~s.strb;
   assign strb_rise = ~p_strb &  s.strb;
   assign rw_rise   = ~p_rw   &  s.rw;
   assign wdata     =  s.dat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_ale  <= BUS_IDLE.ale;
         p_strb <= BUS_IDLE.strb;
         p_rw   <= BUS_IDLE.rw;
      end else begin
         p_ale  <= s.ale;
         p_strb <= s.strb;
         p_rw   <= s.rw;
      end
   end

   // address latch for the strobe-pair style
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adr_q <= '0;
      end else if (pair_style && ale_fall) begin
         adr_q <= s.dat[ADR_W-1:0];
      end
   end

   // read phase tracking for the clocked style
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rph_q  <= 1'b0;
         rsel_q <= 1'b0;
      end else if (!pair_style) begin
         if (strb_fall) begin
            rph_q <= 1'b0;
         end else if (strb_rise && !s.cs_n && s.rw) begin
            rph_q  <= 1'b1;
            rsel_q <= s.ale;
         end
      end
   end

   always_comb begin
      wr_tx    = 1'b0;
      wr_ctrl  = 1'b0;
      rd_clr   = 1'b0;
      drive    = 1'b0;
      sel_stat = 1'b0;
      if (pair_style) begin
         if (rw_rise && !s.cs_n) begin
            wr_tx   = (adr_q == ADR_TX);
            wr_ctrl = (adr_q == ADR_CTRL);
         end
         rd_clr   = strb_rise && !s.cs_n && (adr_q == ADR_STAT);
         drive    = !s.strb && !s.cs_n && adr_q[0];
         sel_stat = adr_q[1];
      end else begin
         if (strb_fall && !s.cs_n && !s.rw) begin
            wr_ctrl =  s.ale;
            wr_tx   = !s.ale;
         end
         rd_clr   = strb_fall && rph_q && rsel_q;
         drive    = rph_q && s.strb;
         sel_stat = rsel_q;
      end
   end

   // R2 R4: a write strobe never targets both registers
   a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_tx && wr_ctrl));

   // R5: clocked-style read data goes away one cycle after the strobe is seen low
   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!pair_style && $past(!pair_style) && !s.strb && !p_strb) |-> !drive);

endmodule

// File: rtl/nbr_status.sv
module nbr_status
   import nbr_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    pd,
   input  logic    det_en,
   input  logic    spb_in,
   input  logic    fax_in,
   input  logic    cpt_in,
   input  logic    rd_clr,
   output status_t stat
);

   status_t nxt_c;
   logic    rise_evt;
   logic    all_idle;

   always_comb begin
      nxt_c.spb = pd | spb_in;
      nxt_c.cpt = !pd & det_en & cpt_in;
      nxt_c.fax = !pd & det_en & fax_in & !cpt_in;
      rise_evt  = (stat.spb & !nxt_c.spb) | (!stat.fax & nxt_c.fax) | (!stat.cpt & nxt_c.cpt);
      all_idle  = nxt_c.spb & !nxt_c.fax & !nxt_c.cpt;
      if (pd)                      nxt_c.evt = 1'b0;
      else if (rise_evt)           nxt_c.evt = 1'b1;
      else if (rd_clr || all_idle) nxt_c.evt = 1'b0;
      else                         nxt_c.evt = stat.evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= STAT_IDLE;
      else        stat <= nxt_c;
   end

   a_r8_evt_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat.spb) |-> stat.evt);

   a_r10_evt_needs_activity: assert property (@(posedge clk) disable iff (!rst_n)
      stat.evt |-> (!stat.spb || stat.fax || stat.cpt));

   a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !det_en |=> (!stat.fax && !stat.cpt));

   a_r12_fax_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
      stat.cpt |-> !stat.fax);

   a_r13_pd_idle: assert property (@(posedge clk) disable iff (!rst_n)
      pd |=> (stat == STAT_IDLE));

   a_r9_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && stat.spb && !(spb_in === 1'b0) && !fax_in && !cpt_in) |=> !stat.evt);

endmodule

// File: rtl/nibble_bus_regs.sv
module nibble_bus_regs
   import nbr_pkg::*;
#(
   parameter int DATA_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pair_style,
   input  logic              pwr_down,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              ale,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] d_out,
   output logic              d_oe,
   input  logic [DATA_W-1:0] rx_code,
   input  logic              rx_idle,
   input  logic              fax_tone,
   input  logic              cpt_tone,
   output logic [DATA_W-1:0] tx_code,
   output logic              tone_b_en,
   output logic              fast_mode,
   output logic              det_en,
   output logic              tx_en,
   output logic              fax_det,
   output logic              cpt_det
);

   localparam int BUS_W = $bits(bus_t);

   generate
      if (DATA_W != NIB_W) begin : g_bad_data_w
         $error("nibble_bus_regs: DATA_W must match the nibble width");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("nibble_bus_regs: at least two synchronizer stages are required");
      end
   endgenerate

   logic [BUS_W-1:0] raw_bus, sync_bus;
   bus_t             s;
   logic             wr_tx, wr_ctrl, rd_clr, drive, sel_stat;
   logic [NIB_W-1:0] wdata;
   logic [NIB_W-1:0] tx_q;
   ctrl_t            ctrl_q;
   status_t          stat;

   assign raw_bus = {cs_n, rd_n, wr_n, ale, d_in};

   nbr_sync #(
      .W       (BUS_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (BUS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_bus),
      .q     (sync_bus)
   );

   assign s = sync_bus;

   nbr_decode u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .pair_style (pair_style),
      .s          (s),
      .wr_tx      (wr_tx),
      .wr_ctrl    (wr_ctrl),
      .wdata      (wdata),
      .rd_clr     (rd_clr),
      .drive      (drive),
      .sel_stat   (sel_stat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= '0;
         ctrl_q <= '0;
      end else if (pwr_down) begin
         tx_q   <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_tx)   tx_q   <= wdata;
         if (wr_ctrl) ctrl_q <= wdata;
      end
   end

   nbr_status u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .pd     (pwr_down),
      .det_en (ctrl_q.det_en),
      .spb_in (rx_idle),
      .fax_in (fax_tone),
      .cpt_in (cpt_tone),
      .rd_clr (rd_clr),
      .stat   (stat)
   );

   assign d_oe    = drive;
   assign d_out   = drive ? (sel_stat ? stat : rx_code) : '0;
   assign tx_code = tx_q;
   assign {tone_b_en, fast_mode, det_en, tx_en} = ctrl_q;
   assign fax_det = stat.fax;
   assign cpt_det = stat.cpt;

   a_r13_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> (tx_code == '0 && ctrl_q == '0));

   a_r3_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_style && $past(pair_style) && s.cs_n) |-> !d_oe);

endmodule

// File: tb/sim_nibble_bus_regs.sv
module sim_nibble_bus_regs;

   localparam int CLK_P = 10;
   localparam int LIMIT = 200000;

   typedef struct packed {
      logic       cs_n;
      logic       strb;
      logic       rw;
      logic       ale;
      logic [3:0] dat;
   } smp_t;

   localparam smp_t IDLE_S = 8'b1110_0000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pair_style = 1'b1;
   logic       pwr_down = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ale = 1'b0;
   logic [3:0] d_in = 4'h0;
   logic [3:0] d_out;
   logic       d_oe;
   logic [3:0] rx_code = 4'h0;
   logic       rx_idle = 1'b1, fax_tone = 1'b0, cpt_tone = 1'b0;
   logic [3:0] tx_code;
   logic       tone_b_en, fast_mode, det_en, tx_en, fax_det, cpt_det;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_P/2) clk = ~clk;

   nibble_bus_regs u0 (
      .clk(clk), .rst_n(rst_n), .pair_style(pair_style), .pwr_down(pwr_down),
      .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .ale(ale), .d_in(d_in),
      .d_out(d_out), .d_oe(d_oe), .rx_code(rx_code), .rx_idle(rx_idle),
      .fax_tone(fax_tone), .cpt_tone(cpt_tone), .tx_code(tx_code),
      .tone_b_en(tone_b_en), .fast_mode(fast_mode), .det_en(det_en), .tx_en(tx_en),
      .fax_det(fax_det), .cpt_det(cpt_det)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   smp_t       hist[$];
   logic [3:0] m_tx, m_ctrl;
   logic [1:0] m_adr;
   logic       m_rph, m_rsel;
   logic       m_spb, m_fax, m_cpt, m_evt;

   always @(posedge clk) begin
      smp_t s, p;
      logic rclr, wt, wc, n_spb, n_fax, n_cpt, ev, idl, det;
      if (!rst_n) begin
         hist = '{IDLE_S, IDLE_S, IDLE_S};
         m_tx = 0; m_ctrl = 0; m_adr = 0; m_rph = 0; m_rsel = 0;
         m_spb = 1; m_fax = 0; m_cpt = 0; m_evt = 0;
      end else begin
         hist.push_back({cs_n, rd_n, wr_n, ale, d_in});
         p = hist[0];
         s = hist[1];
         void'(hist.pop_front());
         rclr = 0; wt = 0; wc = 0;
         if (pair_style) begin
            if (!p.rw && s.rw && !s.cs_n) begin
               wt = (m_adr == 2'd0);
               wc = (m_adr == 2'd2);
            end
            if (!p.strb && s.strb && !s.cs_n && m_adr == 2'd3) rclr = 1;
            if (p.ale && !s.ale) m_adr = s.dat[1:0];
         end else begin
            if (p.strb && !s.strb) begin
               if (!s.cs_n && !s.rw) begin wc = s.ale; wt = !s.ale; end
               if (m_rph && m_rsel) rclr = 1;
               m_rph = 0;
            end else if (!p.strb && s.strb && !s.cs_n && s.rw) begin
               m_rph = 1;
               m_rsel = s.ale;
            end
         end
         det   = m_ctrl[1];
         n_spb = pwr_down | rx_idle;
         n_cpt = !pwr_down & det & cpt_tone;
         n_fax = !pwr_down & det & fax_tone & !cpt_tone;
         ev    = (m_spb & !n_spb) | (!m_fax & n_fax) | (!m_cpt & n_cpt);
         idl   = n_spb & !n_fax & !n_cpt;
         if (pwr_down)        m_evt = 0;
         else if (ev)         m_evt = 1;
         else if (rclr | idl) m_evt = 0;
         m_spb = n_spb; m_fax = n_fax; m_cpt = n_cpt;
         if (pwr_down) begin
            m_tx = 0; m_ctrl = 0;
         end else begin
            if (wt) m_tx = s.dat;
            if (wc) m_ctrl = s.dat;
         end
      end
   end

   always @(negedge clk) begin
      smp_t c;
      logic oe_e, sel;
      logic [3:0] do_e;
      #(CLK_P/4);
      if (rst_n && hist.size() == 3) begin
         c    = hist[1];
         oe_e = pair_style ? (!c.strb && !c.cs_n && m_adr[0]) : (m_rph && c.strb);
         sel  = pair_style ? m_adr[1] : m_rsel;
         do_e = oe_e ? (sel ? {m_spb, m_fax, m_cpt, m_evt} : rx_code) : 4'h0;
         chk("R2 R4 R13 model tx_code", tx_code, m_tx);
         chk("R6 model control pins", {tone_b_en, fast_mode, det_en, tx_en}, m_ctrl);
         chk("R11 R12 model detector pins", {fax_det, cpt_det}, {m_fax, m_cpt});
         chk("R3 R5 model d_oe", d_oe, oe_e);
         chk("R7 R8 R9 R10 model d_out", d_out, do_e);
      end
   end

   // ---------------- bus tasks ----------------
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pair_addr(input logic [1:0] a);
      @(negedge clk); ale = 1; d_in = {2'b00, a};
      idle(3); ale = 0;
      idle(3);
   endtask

   task automatic pair_write(input logic [1:0] a, input logic [3:0] v, input logic sel);
      pair_addr(a);
      d_in = v; cs_n = !sel;
      idle(2); wr_n = 0;
      idle(3); wr_n = 1;
      idle(3); cs_n = 1;
      idle(2);
   endtask

   task automatic pair_read(input logic [1:0] a, output logic [3:0] v, output logic oe);
      pair_addr(a);
      cs_n = 0; rd_n = 0;
      idle(4);
      #1; v = d_out; oe = d_oe;
      @(negedge clk); rd_n = 1;
      idle(3); cs_n = 1;
      idle(3);
   endtask

   task automatic clk_write(input logic sel_ctrl, input logic [3:0] v, input logic sel);
      @(negedge clk); cs_n = !sel; wr_n = 0; ale = sel_ctrl; d_in = v;
      idle(2); rd_n = 1;
      idle(3); rd_n = 0;
      idle(3); cs_n = 1; wr_n = 1;
      idle(2);
   endtask

   task automatic clk_read(input logic sel_stat, output logic [3:0] v,
                           output logic oe_hi, output logic oe_lo);
      @(negedge clk); cs_n = 0; wr_n = 1; ale = sel_stat;
      idle(2); rd_n = 1;
      idle(4);
      #1; v = d_out; oe_hi = d_oe;
      @(negedge clk); rd_n = 0;
      idle(3);
      #1; oe_lo = d_oe;
      cs_n = 1;
      idle(2);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (LIMIT) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=%0d expected=done", LIMIT);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   // ---------------- directed sequence ----------------
   initial begin
      logic [3:0] v;
      logic oe, oe2;
      idle(4);
      rst_n = 1;
      idle(3);
      chk("R1 reset tx_code", tx_code, 4'h0);
      chk("R1 reset control", {tone_b_en, fast_mode, det_en, tx_en}, 4'h0);
      chk("R1 reset d_oe", d_oe, 1'b0);
      pair_read(2'd3, v, oe);
      chk("R1 R7 reset status", v, 4'b1000);

      pair_write(2'd0, 4'h5, 1);
      chk("R2 tx write", tx_code, 4'h5);
      pair_write(2'd2, 4'b1010, 1);
      chk("R6 control fields", {tone_b_en, fast_mode, det_en, tx_en}, 4'b1010);
      pair_write(2'd1, 4'hF, 1);
      chk("R2 write to read-only addr", {tx_code, tone_b_en, fast_mode, det_en, tx_en}, 8'h5A);
      pair_write(2'd0, 4'h3, 0);
      chk("R2 write without select", tx_code, 4'h5);

      rx_code = 4'h9;
      pair_read(2'd1, v, oe);
      chk("R3 receive read data", v, 4'h9);
      chk("R3 receive read enable", oe, 1'b1);
      pair_read(2'd0, v, oe);
      chk("R3 write-only addr not driven", oe, 1'b0);

      cpt_tone = 1; idle(4);
      chk("R8 cpt pin", cpt_det, 1'b1);
      pair_read(2'd3, v, oe);
      chk("R8 R7 status after cpt", v, 4'b1011);
      pair_read(2'd3, v, oe);
      chk("R9 status after read clear", v, 4'b1010);
      fax_tone = 1; idle(4);
      chk("R12 fax held while cpt", fax_det, 1'b0);
      cpt_tone = 0; idle(4);
      chk("R12 fax after cpt gone", fax_det, 1'b1);
      fax_tone = 0; idle(4);
      pair_read(2'd3, v, oe);
      chk("R10 auto clear without read", v, 4'b1000);
      fax_tone = 1; idle(4);
      pair_read(2'd3, v, oe);
      chk("R8 fax rise event", v, 4'b1101);
      fax_tone = 0; idle(4);

      rx_idle = 0; idle(4);
      pair_read(2'd3, v, oe);
      chk("R8 busy fall event", v, 4'b0001);
      pair_read(2'd3, v, oe);
      chk("R9 busy event read clear", v, 4'b0000);

      pair_write(2'd2, 4'b0000, 1);
      cpt_tone = 1; fax_tone = 1; idle(4);
      chk("R11 pins gated", {fax_det, cpt_det}, 2'b00);
      pair_read(2'd3, v, oe);
      chk("R11 status gated", v, 4'b0000);
      rx_idle = 1; idle(4);

      @(negedge clk); rd_n = 0;
      idle(2); pair_style = 0;
      idle(3);
      clk_write(1'b0, 4'h3, 1);
      chk("R4 clocked tx write", tx_code, 4'h3);
      clk_write(1'b1, 4'b0110, 1);
      chk("R4 R6 clocked control write", {tone_b_en, fast_mode, det_en, tx_en}, 4'b0110);
      clk_write(1'b0, 4'hC, 0);
      chk("R4 clocked write without select", tx_code, 4'h3);
      rx_code = 4'h6;
      clk_read(1'b0, v, oe, oe2);
      chk("R5 clocked receive data", v, 4'h6);
      chk("R5 driven while strobe high", oe, 1'b1);
      chk("R5 released while strobe low", oe2, 1'b0);
      clk_read(1'b1, v, oe, oe2);
      chk("R5 R12 clocked status read", v, 4'b1011);
      clk_read(1'b1, v, oe, oe2);
      chk("R9 clocked read clear", v, 4'b1010);

      @(negedge clk); pwr_down = 1;
      idle(4);
      chk("R13 pd tx", tx_code, 4'h0);
      chk("R13 pd control", {tone_b_en, fast_mode, det_en, tx_en}, 4'h0);
      chk("R13 pd detector pins", {fax_det, cpt_det}, 2'b00);
      clk_read(1'b1, v, oe, oe2);
      chk("R13 pd status", v, 4'b1000);
      clk_write(1'b0, 4'h7, 1);
      chk("R13 pd write blocked", tx_code, 4'h0);
      @(negedge clk); pwr_down = 0;
      idle(4);
      chk("R13 after pd tx", tx_code, 4'h0);

      idle(4);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule